// File: doc/BRIEF.md
# Completion and event queue doorbell processor

This block takes 32-bit doorbell words written by a consumer of completion or event queues. It splits each word into its fields and checks that the word is legal. It then updates a small bank of per-queue state. Each queue holds a pending-entry count and an arm flag. A producer-side increment port adds newly written entries to a queue's count. A consumer doorbell removes the entries it has popped and can re-enable notification.

The queue space has two classes: completion queues and event queues. There are `NUM_Q` queues of each class, so the bank holds `2*NUM_Q` slots. Completion queue n is slot n and event queue n is slot `NUM_Q+n`. An armed slot whose count is nonzero raises a one-cycle request on its `notify_o` bit and then disarms.

Malformed doorbells are dropped and reported through a sticky error flag. A doorbell is malformed if it has reserved bits set or a queue id outside the bank. Pops that exceed the pending count are also reported through the same flag. The flag keeps the queue id and class of the first offender.

Top module: `cq_doorbell_proc`

## Requirements
- R1: A doorbell word carries the queue id in bits 9:0, the rearm flag in bit 14, the class in bit 15 (1 = event queue, slot `NUM_Q`+id; 0 = completion queue, slot id) and the popped count in bits 28:16. An accepted doorbell takes effect at the next rising clock edge.
- R2: A doorbell with any of bits 13:10 or 31:29 set is dropped: no pending count and no arm flag changes, and `err_o` is set at the next edge.
- R3: A doorbell whose queue id is at or above `NUM_Q` is dropped in the same way and sets `err_o`.
- R4: An accepted doorbell lowers the slot's pending count by the popped count, clamped at zero. If the popped count exceeds the count available that cycle, `err_o` is set.
- R5: An increment with `inc_valid_i` high adds `inc_num_i` to the selected slot's count, which saturates at 2^`CNT_W`-1. An increment with an id at or above `NUM_Q` is ignored and raises no error.
- R6: When a doorbell and an increment select the same slot in the same cycle, the new count is pending + increment - popped, clamped to the range 0 to 2^`CNT_W`-1. The underflow check of R4 uses pending + increment.
- R7: An accepted doorbell with the rearm flag set makes the slot's `armed_o` bit high after the next edge.
- R8: While a slot is armed and its count is nonzero, its `notify_o` bit is high. After that cycle the slot is disarmed, so the pulse lasts one cycle, unless the same cycle carries a rearm for it.
- R9: `err_o` stays high until reset. `err_qid_o` and `err_evq_o` hold the queue id and class bits of the first offending doorbell and do not change on later errors.
- R10: After reset every slot is disarmed with a zero count, and `notify_o`, `err_o`, `err_qid_o` and `err_evq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| db_valid_i | input | 1 | Single-cycle doorbell write strobe |
| db_data_i | input | 32 | Doorbell word |
| inc_valid_i | input | 1 | Producer increment strobe |
| inc_evq_i | input | 1 | Increment targets an event queue |
| inc_qid_i | input | 10 | Increment queue id |
| inc_num_i | input | INC_W | Number of entries added |
| armed_o | output | 2*NUM_Q | Per-slot arm status |
| notify_o | output | 2*NUM_Q | Per-slot notification request pulse |
| err_o | output | 1 | Sticky bad-doorbell flag |
| err_qid_o | output | 10 | Queue id of the first bad doorbell |
| err_evq_o | output | 1 | Class bit of the first bad doorbell |

## Verification
The hardest case to reach from the ports is a doorbell and an increment that hit the same slot in one cycle near a count boundary. Examples are a pop that only fits because of the same-cycle increment, and a sum that rises past the saturation ceiling before the pop brings it down. The bench uses a narrow count width so the ceiling is reachable, and it sets up these coincidences with directed sequences. Random traffic with a small queue count and small pop and increment sizes then makes same-slot collisions common. The pending count is never shown directly, so it is observed through the notification pulse that follows a rearm.

// File: rtl/cqdb_pkg.sv
package cqdb_pkg;
  localparam int unsigned DB_W  = 32;
  localparam int unsigned QID_W = 10;
  localparam int unsigned POP_W = 13;

  // field order follows the bit layout of the doorbell word, msb first
  typedef struct packed {
    logic [2:0]       rsvd_hi;
    logic [POP_W-1:0] popped;
    logic             evq;
    logic             rearm;
    logic [3:0]       rsvd_lo;
    logic [QID_W-1:0] qid;
  } db_word_t;
endpackage

// File: rtl/cqdb_decode.sv
module cqdb_decode
  import cqdb_pkg::*;
#(
  parameter int unsigned NUM_Q = 8
) (
  input  logic                   db_valid_i,
  input  logic [DB_W-1:0]        db_data_i,
  output logic [2*NUM_Q-1:0]     sel_o,
  output logic                   rearm_o,
  output logic [POP_W-1:0]       popped_o,
  output logic                   bad_o,
  output logic [QID_W-1:0]       qid_o,
  output logic                   evq_o
);
  localparam int unsigned N_SLOT = 2 * NUM_Q;

  db_word_t w;
  logic     rsvd_bad, range_bad, ok;

  assign w         = db_word_t'(db_data_i);
  assign rsvd_bad  = (|w.rsvd_lo) | (|w.rsvd_hi);
  assign range_bad = {22'd0, w.qid} >= NUM_Q;
  assign ok        = db_valid_i & ~rsvd_bad & ~range_bad;
  assign bad_o     = db_valid_i & (rsvd_bad | range_bad);
  assign rearm_o   = w.rearm;
  assign popped_o  = w.popped;
  assign qid_o     = w.qid;
  assign evq_o     = w.evq;

  for (genvar i = 0; i < N_SLOT; i++) begin : g_sel
    localparam logic        EV  = (i >= NUM_Q);
    localparam int unsigned IDX = i % NUM_Q;
    assign sel_o[i] = ok && (w.evq == EV) && (w.qid == QID_W'(IDX));
  end

  // an accepted word addresses exactly one slot, a dropped one none
  always_comb begin
    if (db_valid_i === 1'b1) begin
      assert_one_slot_R1: assert ($onehot0(sel_o) && !(bad_o && (|sel_o)));
    end
  end
endmodule

// File: rtl/cqdb_slot.sv
module cqdb_slot
  import cqdb_pkg::*;
#(
  parameter int unsigned CNT_W = 14,
  parameter int unsigned INC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             db_hit_i,
  input  logic             rearm_i,
  input  logic [POP_W-1:0] popped_i,
  input  logic             inc_hit_i,
  input  logic [INC_W-1:0] inc_num_i,
  output logic             armed_o,
  output logic             notify_o,
  output logic             uflow_o
);
  localparam int unsigned SUM_W = ((CNT_W > POP_W) ? CNT_W : POP_W) + 1;
  localparam logic [SUM_W-1:0] CNT_MAX = {{(SUM_W-CNT_W){1'b0}}, {CNT_W{1'b1}}};

  logic [CNT_W-1:0] pend_q, pend_d;
  logic             armed_q, armed_d;
  logic [SUM_W-1:0] sum, pop_x, rem;

  always_comb begin
    sum     = SUM_W'(pend_q) + (inc_hit_i ? SUM_W'(inc_num_i) : '0);
    pop_x   = db_hit_i ? SUM_W'(popped_i) : '0;
    uflow_o = pop_x > sum;
    rem     = uflow_o ? '0 : sum - pop_x;
    pend_d  = (rem > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : rem[CNT_W-1:0];
  end

  assign notify_o = armed_q & (|pend_q);
  assign armed_d  = (db_hit_i & rearm_i) | (armed_q & ~notify_o);
  assign armed_o  = armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      armed_q <= armed_d;
    end
  end

  assert_rearm_arms_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (db_hit_i && rearm_i) |=> armed_o);

  assert_notify_disarms_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (notify_o && !(db_hit_i && rearm_i)) |=> (!armed_o && !notify_o));

  assert_pop_clamps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (db_hit_i && !inc_hit_i && (SUM_W'(popped_i) >= SUM_W'(pend_q))) |=> (pend_q == '0));

  assert_inc_grows_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_hit_i && !db_hit_i) |=> (pend_q >= $past(pend_q)));
endmodule

// File: rtl/cqdb_err.sv
module cqdb_err
  import cqdb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ev_i,
  input  logic [QID_W-1:0] qid_i,
  input  logic             evq_i,
  output logic             err_o,
  output logic [QID_W-1:0] qid_o,
  output logic             evq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o <= 1'b0;
      qid_o <= '0;
      evq_o <= 1'b0;
    end else if (ev_i && !err_o) begin
      err_o <= 1'b1;
      qid_o <= qid_i;
      evq_o <= evq_i;
    end
  end

  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> (err_o && $stable(qid_o) && $stable(evq_o)));
endmodule

// File: rtl/cq_doorbell_proc.sv
module cq_doorbell_proc
  import cqdb_pkg::*;
#(
  parameter int unsigned NUM_Q = 8,
  parameter int unsigned CNT_W = 14,
  parameter int unsigned INC_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               db_valid_i,
  input  logic [31:0]        db_data_i,
  input  logic               inc_valid_i,
  input  logic               inc_evq_i,
  input  logic [9:0]         inc_qid_i,
  input  logic [INC_W-1:0]   inc_num_i,
  output logic [2*NUM_Q-1:0] armed_o,
  output logic [2*NUM_Q-1:0] notify_o,
  output logic               err_o,
  output logic [9:0]         err_qid_o,
  output logic               err_evq_o
);
  localparam int unsigned N_SLOT = 2 * NUM_Q;

  logic [N_SLOT-1:0] db_sel, inc_sel, uflow;
  logic              rearm, bad, dec_evq;
  logic [POP_W-1:0]  popped;
  logic [QID_W-1:0]  dec_qid;

  cqdb_decode #(.NUM_Q(NUM_Q)) u_dec (
    .db_valid_i (db_valid_i),
    .db_data_i  (db_data_i),
    .sel_o      (db_sel),
    .rearm_o    (rearm),
    .popped_o   (popped),
    .bad_o      (bad),
    .qid_o      (dec_qid),
    .evq_o      (dec_evq)
  );

  for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
    localparam logic        EV  = (i >= NUM_Q);
    localparam int unsigned IDX = i % NUM_Q;
    assign inc_sel[i] = inc_valid_i && (inc_evq_i == EV) && (inc_qid_i == QID_W'(IDX));

    cqdb_slot #(.CNT_W(CNT_W), .INC_W(INC_W)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .db_hit_i  (db_sel[i]),
      .rearm_i   (rearm),
      .popped_i  (popped),
      .inc_hit_i (inc_sel[i]),
      .inc_num_i (inc_num_i),
      .armed_o   (armed_o[i]),
      .notify_o  (notify_o[i]),
      .uflow_o   (uflow[i])
    );
  end

  cqdb_err u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (bad | (|uflow)),
    .qid_i  (dec_qid),
    .evq_i  (dec_evq),
    .err_o  (err_o),
    .qid_o  (err_qid_o),
    .evq_o  (err_evq_o)
  );

  assert_rsvd_flags_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (db_valid_i && ((|db_data_i[13:10]) || (|db_data_i[31:29]))) |=> err_o);

  assert_range_flags_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (db_valid_i && ({22'd0, db_data_i[9:0]} >= NUM_Q)) |=> err_o);

  assert_rsvd_no_arm_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (db_valid_i && (|db_data_i[13:10]) && !inc_valid_i && (notify_o == '0))
      |=> (armed_o == $past(armed_o)));
endmodule

// File: tb/cq_doorbell_proc_test.sv
`timescale 1ns/1ps
module cq_doorbell_proc_test;
  localparam int NQ = 4;
  localparam int CW = 5;
  localparam int IW = 4;
  localparam int NS = 2 * NQ;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          db_valid_i = 1'b0;
  logic [31:0]   db_data_i = '0;
  logic          inc_valid_i = 1'b0;
  logic          inc_evq_i = 1'b0;
  logic [9:0]    inc_qid_i = '0;
  logic [IW-1:0] inc_num_i = '0;
  logic [NS-1:0] armed_o, notify_o;
  logic          err_o, err_evq_o;
  logic [9:0]    err_qid_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  int       m_pend [NS];
  bit       m_arm  [NS];
  bit       m_err;
  bit [9:0] m_eqid;
  bit       m_eevq;

  always #2.5 clk = ~clk;

  cq_doorbell_proc #(.NUM_Q(NQ), .CNT_W(CW), .INC_W(IW)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .db_valid_i(db_valid_i), .db_data_i(db_data_i),
    .inc_valid_i(inc_valid_i), .inc_evq_i(inc_evq_i),
    .inc_qid_i(inc_qid_i), .inc_num_i(inc_num_i),
    .armed_o(armed_o), .notify_o(notify_o),
    .err_o(err_o), .err_qid_o(err_qid_o), .err_evq_o(err_evq_o)
  );

  function automatic logic [31:0] dbw(int q, bit ev, bit rearm, int pop);
    logic [31:0] w = '0;
    w[9:0]   = q[9:0];
    w[14]    = rearm;
    w[15]    = ev;
    w[28:16] = pop[12:0];
    return w;
  endfunction

  function automatic logic [NS-1:0] exp_arm();
    logic [NS-1:0] v;
    for (int s = 0; s < NS; s++) v[s] = m_arm[s];
    return v;
  endfunction

  function automatic logic [NS-1:0] exp_notify();
    logic [NS-1:0] v;
    for (int s = 0; s < NS; s++) v[s] = m_arm[s] && (m_pend[s] != 0);
    return v;
  endfunction

  task automatic check_all(input string ph);
    n_chk++;
    if (armed_o !== exp_arm()) begin
      n_bad++;
      $display("FAIL [%s/R7] armed_o got %b exp %b", ph, armed_o, exp_arm());
    end
    n_chk++;
    if (notify_o !== exp_notify()) begin
      n_bad++;
      $display("FAIL [%s/R8] notify_o got %b exp %b", ph, notify_o, exp_notify());
    end
    n_chk++;
    if ({err_o, err_qid_o, err_evq_o} !== {m_err, m_eqid, m_eevq}) begin
      n_bad++;
      $display("FAIL [%s/R9] err got %b/%0d/%b exp %b/%0d/%b", ph,
               err_o, err_qid_o, err_evq_o, m_err, m_eqid, m_eevq);
    end
  endtask

  task automatic model_update(logic dv, logic [31:0] dd, logic iv, logic ie,
                              logic [9:0] iq, logic [IW-1:0] inum);
    bit rsvd = (|dd[13:10]) || (|dd[31:29]);
    int q    = int'(dd[9:0]);
    bit ev   = dd[15];
    bit ok   = dv && !rsvd && (q < NQ);
    bit bad  = dv && !ok;
    int dslot = ev ? NQ + q : q;
    int islot = ie ? NQ + int'(iq) : int'(iq);
    bit uf_any = 1'b0;
    for (int s = 0; s < NS; s++) begin
      int  sum = m_pend[s] + ((iv && int'(iq) < NQ && islot == s) ? int'(inum) : 0);
      bit  hit = ok && (dslot == s);
      int  pop = hit ? int'(dd[28:16]) : 0;
      bit  fired = m_arm[s] && (m_pend[s] != 0);
      int  r;
      if (pop > sum) begin uf_any = 1'b1; r = 0; end
      else r = sum - pop;
      m_pend[s] = (r > CMAX) ? CMAX : r;
      m_arm[s]  = (hit && dd[14]) ? 1'b1 : (fired ? 1'b0 : m_arm[s]);
    end
    if (!m_err && (bad || uf_any)) begin
      m_err  = 1'b1;
      m_eqid = dd[9:0];
      m_eevq = ev;
    end
  endtask

  task automatic step(input string ph, logic dv, logic [31:0] dd, logic iv,
                      logic ie, logic [9:0] iq, logic [IW-1:0] inum);
    check_all(ph);
    db_valid_i = dv; db_data_i = dd;
    inc_valid_i = iv; inc_evq_i = ie; inc_qid_i = iq; inc_num_i = inum;
    model_update(dv, dd, iv, ie, iq, inum);
    @(negedge clk);
  endtask

  task automatic idle(input string ph, int n);
    for (int k = 0; k < n; k++) step(ph, 1'b0, '0, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    db_valid_i = 1'b0; inc_valid_i = 1'b0;
    for (int s = 0; s < NS; s++) begin m_pend[s] = 0; m_arm[s] = 1'b0; end
    m_err = 1'b0; m_eqid = '0; m_eevq = 1'b0;
    repeat (2) @(negedge clk);
    check_all("R10");
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL [watchdog] run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    // R5 increment, R1/R7 rearm doorbell, R8 one pulse
    step("R5", 1'b0, '0, 1'b1, 1'b0, 10'd2, 4'd3);
    step("R1", 1'b1, dbw(2, 0, 1, 1), 1'b0, 1'b0, '0, '0);
    idle("R8", 3);

    // R1 event queue slot: pops to zero, arms, then increment fires
    step("R5", 1'b0, '0, 1'b1, 1'b1, 10'd1, 4'd5);
    step("R1", 1'b1, dbw(1, 1, 1, 5), 1'b0, 1'b0, '0, '0);
    idle("R7", 2);
    step("R8", 1'b0, '0, 1'b1, 1'b1, 10'd1, 4'd1);
    idle("R8", 2);

    // R5 saturation: 45 clamps to 31, popping 31 gives zero with no error
    for (int k = 0; k < 3; k++) step("R5", 1'b0, '0, 1'b1, 1'b0, 10'd0, 4'd15);
    step("R5", 1'b1, dbw(0, 0, 1, CMAX), 1'b0, 1'b0, '0, '0);
    idle("R5", 2);

    // R6 same slot, same cycle: 0 + 4 - 3 = 1, no underflow, then notify
    step("R6", 1'b1, dbw(3, 0, 1, 3), 1'b1, 1'b0, 10'd3, 4'd4);
    idle("R6", 2);
    // R6 ceiling before pop: 31 + 15 - 10 = 31 after clamp
    step("R6", 1'b0, '0, 1'b1, 1'b0, 10'd3, 4'd15);
    step("R6", 1'b0, '0, 1'b1, 1'b0, 10'd3, 4'd15);
    step("R6", 1'b1, dbw(3, 0, 0, 10), 1'b1, 1'b0, 10'd3, 4'd15);
    step("R6", 1'b1, dbw(3, 0, 1, CMAX), 1'b0, 1'b0, '0, '0);
    idle("R6", 2);

    // R3 out of range id; first capture is qid 6, class 1
    step("R3", 1'b1, dbw(6, 1, 1, 0), 1'b0, 1'b0, '0, '0);
    idle("R3", 1);
    // R2 reserved bits: pop and rearm ignored, capture unchanged (R9)
    step("R2", 1'b0, '0, 1'b1, 1'b0, 10'd1, 4'd2);
    step("R2", 1'b1, dbw(1, 0, 1, 2) | 32'h0000_0800, 1'b0, 1'b0, '0, '0);
    step("R2", 1'b1, dbw(1, 0, 1, 2) | 32'h2000_0000, 1'b0, 1'b0, '0, '0);
    idle("R2", 2);
    step("R2", 1'b1, dbw(1, 0, 1, 0), 1'b0, 1'b0, '0, '0);
    idle("R9", 3);

    // R4 underflow clamps and captures; R5 out-of-range increment ignored
    do_reset();
    step("R5", 1'b0, '0, 1'b1, 1'b0, 10'd4, 4'd9);
    step("R5", 1'b0, '0, 1'b1, 1'b1, 10'd7, 4'd9);
    idle("R5", 1);
    step("R4", 1'b0, '0, 1'b1, 1'b0, 10'd2, 4'd2);
    step("R4", 1'b1, dbw(2, 0, 0, 5), 1'b0, 1'b0, '0, '0);
    step("R4", 1'b1, dbw(2, 0, 1, 0), 1'b0, 1'b0, '0, '0);
    idle("R4", 3);

    // random traffic
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      logic        dv = ($urandom_range(0, 1) == 1);
      logic [31:0] dd = dbw($urandom_range(0, NQ + 1), $urandom_range(0, 1) == 1,
                            $urandom_range(0, 9) < 3, $urandom_range(0, 3));
      logic        iv = ($urandom_range(0, 1) == 1);
      logic        ie = ($urandom_range(0, 1) == 1);
      logic [9:0]  iq = 10'($urandom_range(0, NQ));
      logic [IW-1:0] inum = IW'($urandom_range(0, 5));
      if ($urandom_range(0, 99) < 3) dd[$urandom_range(10, 13)] = 1'b1;
      if ($urandom_range(0, 99) < 2) dd[$urandom_range(29, 31)] = 1'b1;
      if ($urandom_range(0, 99) < 3) dd[28:16] = 13'd31;
      step("R6", dv, dd, iv, ie, iq, inum);
    end
    idle("R8", 2);
    check_all("end");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule